// File: doc/BRIEF.md
# Parallel Flash Byte Program Controller

This controller sits on the host side of a byte-wide parallel flash bus and turns one program request into a complete program-and-poll transaction. A request carries a target address and a data byte. Once it is accepted, the controller drives the four-write command sequence onto the bus. It then reads the status byte from the target address until the device reports that it has finished, or until the operation has failed. A last read-back then confirms that the stored byte equals the requested one.

Each bus cycle takes three clocks. In the first clock the address and data are set up. In the second the strobe is low. In the third the strobe is high again and the address and data are still held. Completion is judged by the toggle rule and the data-polling rule together. Status bit 5 is treated as the device's timing-limit flag. A poll counter puts an upper bound on how long the controller waits. Every outcome ends with a one-clock `done` pulse, and `err` is valid in that same clock.

Top module: `flash_prog_ctrl`

## Requirements
- R1: After reset `req_ready` is 1, `done` is 0, and both `bus_we_n` and `bus_oe_n` are 1.
- R2: An accepted request produces exactly four writes, in this order: 0xAA to address 0x555, 0x55 to address 0x2AA, 0xA0 to address 0x555, then the request data to the request address. The upper address bits of the three command writes are zero.
- R3: Each write holds its address and data stable from the clock before the falling strobe edge through the rising strobe edge. The write strobe is low for exactly one clock. The write strobe and the read strobe are never low at the same time.
- R4: Polling succeeds only when bit 6 of the status byte reads the same on two consecutive reads and status bits 7 and 6 both equal bits 7 and 6 of the requested data. No decision is made while bit 6 is still toggling, even if bit 7 already matches.
- R5: If status bit 5 reads 1 on a poll that has not succeeded, the controller makes exactly two more status reads. If bit 6 differs between those two reads, it finishes with `err`=1 and makes no verify read.
- R6: If bit 6 is equal across those two extra reads, the controller goes on to the verify read, and the result of that read alone sets `err`.
- R7: After polling succeeds, one verify read of the target address compares all eight bits with the requested data and sets `err` on any mismatch. This covers a request that tries to turn a stored 0 into a 1.
- R8: If polling has neither succeeded nor seen bit 5 after POLL_MAX status reads, the controller finishes with `err`=1 and makes no further read.
- R9: `req_ready` goes low in the clock after a request is accepted and stays low until `done` has pulsed. `done` lasts exactly one clock, and `req_ready` is 1 again in the next clock.
- R10: `req_valid` has no effect while an operation is in progress. No extra program sequence is issued and no other address is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Program request present |
| req_addr | input | AW | Target byte address |
| req_data | input | 8 | Byte to program |
| req_ready | output | 1 | Controller idle; a request is accepted when both valid and ready are high |
| done | output | 1 | One-clock end-of-operation pulse |
| err | output | 1 | Operation failed; valid only while `done` is high |
| bus_addr | output | AW | Flash bus address |
| bus_wdata | output | 8 | Flash bus write data |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_oe_n | output | 1 | Read strobe, active low |
| bus_rdata | input | 8 | Flash bus read data |

## Verification
The bench drives the controller against a behavioural flash model that can be set to finish after a given number of polls, to stay busy forever, to raise bit 5 and then either keep toggling or settle, or to report a matching bit 7 while bit 6 still toggles. Skipping the toggle rule would make the controller read back a status byte in place of the data and report a false error. Leaving out the two extra reads after bit 5, or not checking them, changes the read count or the error result. Dropping the verify read would report success for a request that tries to raise a cleared bit. A wrong poll limit shows up as the wrong number of reads before the timeout error. A controller that accepts requests while busy issues a second program sequence, and the model counts it.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNLK_A,
    ST_UNLK_B,
    ST_CMD,
    ST_PROG,
    ST_POLL,
    ST_Q5CHK,
    ST_VERIFY,
    ST_DONE
  } fpc_state_e;

  localparam logic [1:0] PH_SETUP  = 2'd0;
  localparam logic [1:0] PH_STROBE = 2'd1;
  localparam logic [1:0] PH_HOLD   = 2'd2;

  localparam logic [7:0] CMD_UNLK_A = 8'hAA;
  localparam logic [7:0] CMD_UNLK_B = 8'h55;
  localparam logic [7:0] CMD_PROG   = 8'hA0;

  function automatic logic fpc_is_write(fpc_state_e s);
    return (s == ST_UNLK_A) || (s == ST_UNLK_B) || (s == ST_CMD) || (s == ST_PROG);
  endfunction

  function automatic logic fpc_is_read(fpc_state_e s);
    return (s == ST_POLL) || (s == ST_Q5CHK) || (s == ST_VERIFY);
  endfunction

endpackage

// File: rtl/fpc_rst_sync.sv
module fpc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/fpc_bus_drv.sv
module fpc_bus_drv
  import fpc_pkg::*;
#(
  parameter int AW          = 19,
  parameter int UNLK_ADDR_A = 'h555,
  parameter int UNLK_ADDR_B = 'h2AA
) (
  input  fpc_state_e    state,
  input  logic [1:0]    phase,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    tgt_data,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  output logic          bus_we_n,
  output logic          bus_oe_n
);

  localparam logic [AW-1:0] ADDR_A = AW'(UNLK_ADDR_A);
  localparam logic [AW-1:0] ADDR_B = AW'(UNLK_ADDR_B);

  always_comb begin
    case (state)
      ST_UNLK_A: begin
        bus_addr  = ADDR_A;
        bus_wdata = CMD_UNLK_A;
      end
      ST_UNLK_B: begin
        bus_addr  = ADDR_B;
        bus_wdata = CMD_UNLK_B;
      end
      ST_CMD: begin
        bus_addr  = ADDR_A;
        bus_wdata = CMD_PROG;
      end
      default: begin
        bus_addr  = tgt_addr;
        bus_wdata = tgt_data;
      end
    endcase
  end

  assign bus_we_n = !(fpc_is_write(state) && (phase == PH_STROBE));
  assign bus_oe_n = !(fpc_is_read(state) && (phase != PH_SETUP));

endmodule

// File: rtl/fpc_poll_eval.sv
module fpc_poll_eval (
  input  logic [7:0] rdata,
  input  logic [7:0] want,
  input  logic       prev_q6,
  input  logic       prev_valid,
  output logic       poll_ok,
  output logic       limit_flag,
  output logic       byte_match
);

  logic q6_steady;
  logic top_bits_match;

  assign q6_steady      = prev_valid && (rdata[6] == prev_q6);
  assign top_bits_match = (rdata[7] == want[7]) && (rdata[6] == want[6]);
  assign poll_ok        = q6_steady && top_bits_match;
  assign limit_flag     = rdata[5];
  assign byte_match     = (rdata == want);

endmodule

// File: rtl/fpc_poll_cnt.sv
module fpc_poll_cnt #(
  parameter int POLL_MAX = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);

  localparam int CW = $clog2(POLL_MAX + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = clr || inc;

  always_comb begin
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign at_limit = (cnt_q == CW'(POLL_MAX - 1));

endmodule

// File: rtl/flash_prog_ctrl.sv
module flash_prog_ctrl
  import fpc_pkg::*;
#(
  parameter int AW          = 19,
  parameter int POLL_MAX    = 64,
  parameter int UNLK_ADDR_A = 'h555,
  parameter int UNLK_ADDR_B = 'h2AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_data,
  output logic          req_ready,
  output logic          done,
  output logic          err,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  output logic          bus_we_n,
  output logic          bus_oe_n,
  input  logic [7:0]    bus_rdata
);

  logic          rst_sync_n;
  fpc_state_e    state_q,   state_d;
  logic [1:0]    phase_q,   phase_d;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic          err_q,     err_d;
  logic          prev_q6_q, prev_q6_d;
  logic          prev_v_q,  prev_v_d;
  logic          chk_q6_q,  chk_q6_d;
  logic          chk_idx_q, chk_idx_d;
  logic          load_en;
  logic          cnt_clr, cnt_inc, at_limit;
  logic          poll_ok, limit_flag, byte_match;
  logic          step_last;

  fpc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fpc_bus_drv #(
    .AW          (AW),
    .UNLK_ADDR_A (UNLK_ADDR_A),
    .UNLK_ADDR_B (UNLK_ADDR_B)
  ) u_bus_drv (
    .state     (state_q),
    .phase     (phase_q),
    .tgt_addr  (addr_q),
    .tgt_data  (data_q),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we_n  (bus_we_n),
    .bus_oe_n  (bus_oe_n)
  );

  fpc_poll_eval u_poll_eval (
    .rdata      (bus_rdata),
    .want       (data_q),
    .prev_q6    (prev_q6_q),
    .prev_valid (prev_v_q),
    .poll_ok    (poll_ok),
    .limit_flag (limit_flag),
    .byte_match (byte_match)
  );

  fpc_poll_cnt #(.POLL_MAX(POLL_MAX)) u_poll_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .clr      (cnt_clr),
    .inc      (cnt_inc),
    .at_limit (at_limit)
  );

  assign step_last = (phase_q == PH_HOLD);
  assign load_en   = (state_q == ST_IDLE) && req_valid;

  always_comb begin
    state_d   = state_q;
    phase_d   = phase_q;
    err_d     = err_q;
    prev_q6_d = prev_q6_q;
    prev_v_d  = prev_v_q;
    chk_q6_d  = chk_q6_q;
    chk_idx_d = chk_idx_q;
    cnt_clr   = 1'b0;
    cnt_inc   = 1'b0;

    if (fpc_is_write(state_q) || fpc_is_read(state_q)) begin
      phase_d = step_last ? PH_SETUP : phase_q + 2'd1;
    end

    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          state_d = ST_UNLK_A;
          phase_d = PH_SETUP;
          err_d   = 1'b0;
          cnt_clr = 1'b1;
        end
      end
      ST_UNLK_A: if (step_last) state_d = ST_UNLK_B;
      ST_UNLK_B: if (step_last) state_d = ST_CMD;
      ST_CMD:    if (step_last) state_d = ST_PROG;
      ST_PROG: begin
        if (step_last) begin
          state_d  = ST_POLL;
          prev_v_d = 1'b0;
        end
      end
      ST_POLL: begin
        if (step_last) begin
          cnt_inc = 1'b1;
          if (poll_ok) begin
            state_d = ST_VERIFY;
          end else if (limit_flag) begin
            state_d   = ST_Q5CHK;
            chk_idx_d = 1'b0;
          end else if (at_limit) begin
            state_d = ST_DONE;
            err_d   = 1'b1;
          end else begin
            prev_q6_d = bus_rdata[6];
            prev_v_d  = 1'b1;
          end
        end
      end
      ST_Q5CHK: begin
        if (step_last) begin
          if (!chk_idx_q) begin
            chk_q6_d  = bus_rdata[6];
            chk_idx_d = 1'b1;
          end else if (bus_rdata[6] != chk_q6_q) begin
            state_d = ST_DONE;
            err_d   = 1'b1;
          end else begin
            state_d = ST_VERIFY;
          end
        end
      end
      ST_VERIFY: begin
        if (step_last) begin
          state_d = ST_DONE;
          err_d   = !byte_match;
        end
      end
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q   <= ST_IDLE;
      phase_q   <= PH_SETUP;
      err_q     <= 1'b0;
      prev_q6_q <= 1'b0;
      prev_v_q  <= 1'b0;
      chk_q6_q  <= 1'b0;
      chk_idx_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      phase_q   <= phase_d;
      err_q     <= err_d;
      prev_q6_q <= prev_q6_d;
      prev_v_q  <= prev_v_d;
      chk_q6_q  <= chk_q6_d;
      chk_idx_q <= chk_idx_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load_en) begin
      addr_q <= req_addr;
      data_q <= req_data;
    end
  end

  assign req_ready = (state_q == ST_IDLE);
  assign done      = (state_q == ST_DONE);
  assign err       = done && err_q;

endmodule

// File: rtl/fpc_chk.sv
module fpc_chk #(
  parameter int AW       = 19,
  parameter int POLL_MAX = 64
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic [AW-1:0] bus_addr,
  input logic [7:0]    bus_wdata,
  input logic          bus_we_n,
  input logic          bus_oe_n
);

  localparam int RCW = $clog2(POLL_MAX + 8) + 1;

  logic [RCW-1:0] rd_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_cnt <= '0;
    end else if (req_valid && req_ready) begin
      rd_cnt <= '0;
    end else if ($fell(bus_oe_n)) begin
      rd_cnt <= rd_cnt + RCW'(1);
    end
  end

  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_we_n && !bus_oe_n));

  // R3
  we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_we_n |=> bus_we_n);

  // R3
  wr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_we_n) |-> ($stable(bus_addr) && $stable(bus_wdata)));

  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_we_n) |-> ($stable(bus_addr) && $stable(bus_wdata)));

  // R9
  ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !req_ready);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));

  // R8
  poll_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= RCW'(POLL_MAX + 3));

endmodule

bind flash_prog_ctrl fpc_chk #(.AW(AW), .POLL_MAX(POLL_MAX)) u_fpc_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .done      (done),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_we_n  (bus_we_n),
  .bus_oe_n  (bus_oe_n)
);

// File: tb/test_flash_prog_ctrl.sv
`timescale 1ns/1ps
module test_flash_prog_ctrl;

  localparam int AW       = 19;
  localparam int POLL_MAX = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0]    req_data = '0;
  logic          req_ready, done, err;
  logic [AW-1:0] bus_addr;
  logic [7:0]    bus_wdata;
  logic          bus_we_n, bus_oe_n;
  logic [7:0]    bus_rdata;

  always #2.5 clk = ~clk;

  flash_prog_ctrl #(.AW(AW), .POLL_MAX(POLL_MAX)) i_flash_prog_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .req_ready(req_ready), .done(done), .err(err),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we_n(bus_we_n),
    .bus_oe_n(bus_oe_n), .bus_rdata(bus_rdata)
  );

  int n_tests = 0;
  int n_fail  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural flash model
  bit            resp_on = 1'b0;
  logic [7:0]    fmem [16];
  logic [AW-1:0] lat_addr;
  logic [AW-1:0] prog_addr;
  logic [7:0]    pdata = 8'h00;
  int  seq_idx = 0, seq_err = 0, prog_cnt = 0;
  int  stat_reads = 0, all_reads = 0, busy_left = 0, q5_at = 0;
  bit  busy_inf = 1'b0, q5_en = 1'b0, q7_fake = 1'b0, tog = 1'b0;
  logic stat;

  assign stat = (busy_left > 0) || busy_inf;
  assign bus_rdata = stat ? {(q7_fake ? pdata[7] : ~pdata[7]), tog,
                             (q5_en && (stat_reads >= q5_at)), 5'b0}
                          : fmem[bus_addr[3:0]];

  always @(negedge bus_we_n) if (resp_on) lat_addr = bus_addr;

  always @(posedge bus_we_n) begin
    if (resp_on) begin
      if (bus_addr != lat_addr) seq_err++;
      case (seq_idx)
        0: if (lat_addr != AW'('h555) || bus_wdata != 8'hAA) seq_err++;
        1: if (lat_addr != AW'('h2AA) || bus_wdata != 8'h55) seq_err++;
        2: if (lat_addr != AW'('h555) || bus_wdata != 8'hA0) seq_err++;
        default: begin
          prog_cnt++;
          prog_addr = lat_addr;
          pdata = bus_wdata;
          fmem[lat_addr[3:0]] = fmem[lat_addr[3:0]] & bus_wdata;
        end
      endcase
      seq_idx = (seq_idx == 3) ? 0 : seq_idx + 1;
    end
  end

  always @(posedge bus_oe_n) begin
    if (resp_on) begin
      all_reads++;
      if (stat) begin
        stat_reads++;
        tog = ~tog;
        if (busy_left > 0) busy_left--;
      end
    end
  end

  int strobe_overlap = 0;
  bit in_op = 1'b0;
  int rdy_viol = 0;
  always @(negedge clk) begin
    if (!bus_we_n && !bus_oe_n) strobe_overlap++;
    if (in_op && req_ready) rdy_viol++;
  end

  initial begin
    int wd = 0;
    while (wd < 150000) begin
      @(posedge clk);
      wd++;
    end
    n_fail++;
    n_tests++;
    $display("FAIL watchdog: actual %0d expected %0d", wd, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  task automatic run_op(input logic [AW-1:0] a, input logic [7:0] d,
                        input int busy, input bit inf, input bit q5e,
                        input int q5a, input bit q7f, input bit poke,
                        output bit got_err);
    bit seen = 1'b0;
    busy_left = 0; busy_inf = 1'b0; q5_en = q5e; q5_at = q5a;
    q7_fake = q7f; tog = 1'b0; seq_idx = 0; seq_err = 0; prog_cnt = 0;
    stat_reads = 0; all_reads = 0; strobe_overlap = 0; rdy_viol = 0;
    got_err = 1'b0;
    req_addr = a; req_data = d; req_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    in_op = 1'b1;
    // model goes busy once the program write lands; arm it now
    busy_left = busy; busy_inf = inf;
    for (int c = 0; c < 4000; c++) begin
      if (done) begin
        got_err = err;
        seen = 1'b1;
        break;
      end
      if (poke && c < 12) begin
        req_valid = 1'b1; req_addr = a ^ AW'(4); req_data = 8'h00;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    in_op = 1'b0;
    req_valid = 1'b0;
    check(seen, "R9", "done seen", seen, 1);
    @(negedge clk);
    check(!done && req_ready, "R9", "done one clock then ready",
          {done, req_ready}, 2'b01);
    check(rdy_viol == 0, "R9", "ready low while busy", rdy_viol, 0);
    check(seq_err == 0, "R2", "command sequence and hold", seq_err, 0);
    check(strobe_overlap == 0, "R3", "strobe overlap", strobe_overlap, 0);
    busy_inf = 1'b0; busy_left = 0;
  endtask

  task automatic t_reset();
    check(req_ready == 1'b1, "R1", "ready after reset", req_ready, 1);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(bus_we_n == 1'b1, "R1", "we_n after reset", bus_we_n, 1);
    check(bus_oe_n == 1'b1, "R1", "oe_n after reset", bus_oe_n, 1);
  endtask

  task automatic t_normal();
    bit e;
    fmem[3] = 8'hFF;
    run_op(AW'('h40003), 8'h5A, 6, 0, 0, 0, 0, 0, e);
    check(e == 1'b0, "R4", "normal program err", e, 0);
    check(fmem[3] == 8'h5A, "R4", "normal program data", fmem[3], 8'h5A);
    check(prog_cnt == 1, "R2", "one program write", prog_cnt, 1);
    check(prog_addr == AW'('h40003), "R2", "program address", prog_addr, 'h40003);
  endtask

  task automatic t_q7_early();
    bit e;
    fmem[9] = 8'hFF;
    // bit 7 matches during busy; only the toggle rule can hold off
    run_op(AW'('h7FFF9), 8'hA5, 5, 0, 0, 0, 1, 0, e);
    check(e == 1'b0, "R4", "toggle rule holds off completion", e, 0);
    check(fmem[9] == 8'hA5, "R4", "data after toggle hold", fmem[9], 8'hA5);
    check(stat_reads == 5, "R4", "status reads consumed", stat_reads, 5);
  endtask

  task automatic t_verify_fail();
    bit e;
    fmem[5] = 8'hC0;
    run_op(AW'('h00005), 8'hC5, 3, 0, 0, 0, 0, 0, e);
    check(e == 1'b1, "R7", "raise attempt flagged", e, 1);
    check(fmem[5] == 8'hC0, "R7", "cleared bits stay", fmem[5], 8'hC0);
  endtask

  task automatic t_q5_fail();
    bit e;
    fmem[6] = 8'hFF;
    run_op(AW'('h00006), 8'h33, 0, 1, 1, 4, 0, 0, e);
    check(e == 1'b1, "R5", "limit flag with toggling", e, 1);
    check(all_reads == 7, "R5", "reads after limit flag", all_reads, 7);
  endtask

  task automatic t_q5_recover();
    bit e;
    fmem[7] = 8'hFF;
    run_op(AW'('h00007), 8'h6C, 5, 0, 1, 4, 0, 0, e);
    check(e == 1'b0, "R6", "limit flag then settled", e, 0);
    check(all_reads == 8, "R6", "poll+check+verify reads", all_reads, 8);
    check(fmem[7] == 8'h6C, "R6", "data after recovery", fmem[7], 8'h6C);
  endtask

  task automatic t_timeout();
    bit e;
    fmem[8] = 8'hFF;
    run_op(AW'('h00008), 8'h11, 0, 1, 0, 0, 0, 0, e);
    check(e == 1'b1, "R8", "poll timeout err", e, 1);
    check(all_reads == POLL_MAX, "R8", "reads before timeout", all_reads, POLL_MAX);
  endtask

  task automatic t_ignore_busy_req();
    bit e;
    fmem[10] = 8'hFF;
    fmem[14] = 8'hFF;
    run_op(AW'('h0000A), 8'h96, 6, 0, 0, 0, 0, 1, e);
    check(e == 1'b0, "R10", "op with busy request", e, 0);
    check(prog_cnt == 1, "R10", "no extra program", prog_cnt, 1);
    check(fmem[14] == 8'hFF, "R10", "other address untouched", fmem[14], 8'hFF);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) fmem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    resp_on = 1'b1;
    t_normal();
    t_q7_early();
    t_verify_fail();
    t_q5_fail();
    t_q5_recover();
    t_timeout();
    t_ignore_busy_req();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule